// File: doc/BRIEF.md
# Real-Time Counter with Coherent Seconds Shadow

This block is a free-running time-of-day counter driven by a 1 kHz enable from an always-on reference. It holds a milliseconds-within-second count that runs from 0 to 999 and a seconds count that advances each time the milliseconds count rolls over. Because it keeps running while the rest of the system is powered down, software can use it as a persistent, monotonic time base.

Software reads the time as two words. The milliseconds word is read first. On the same clock edge as that read, the block copies the live seconds count into a separate shadow register. Software then reads the shadow word and forms the time as shadow × 1000 + milliseconds. The pair stays consistent even if the milliseconds count wraps between the two reads.

Reads are registered. Data appears one cycle after the offset is presented, and unmapped offsets return zero.

Top module: `rtc_shadow_timer`

## Requirements
- R1: A synchronous reset clears the milliseconds count, the seconds count and the shadow register, so all three mapped offsets read as zero afterwards.
- R2: Each cycle with `tick` high advances the milliseconds count by one. Without `tick`, neither the milliseconds count nor the seconds count changes.
- R3: When the milliseconds count is at 999 and `tick` is high, the milliseconds count becomes 0 and the seconds count rises by one on the same edge.
- R4: The seconds count wraps modulo 2^SEC_W. With the default of 32 bits this is modulo 2^32.
- R5: A read at offset 0x10 loads the shadow register with the seconds value present at that edge, before any increment on that edge. The shadow then holds this value until the next read at 0x10, whatever else is read or ticked.
- R6: A read presented with `rdEn` high returns its data on `rdData` one cycle later. Offset 0x08 returns live seconds, 0x0C returns the shadow and 0x10 returns milliseconds, each zero-extended.
- R7: A read of any other offset returns zero, and so does any cycle in which `rdEn` is low.
- R8: Reading 0x10 and then 0x0C yields a pair whose value shadow × 1000 + milliseconds equals the time at the milliseconds read. This holds when that read coincides with the 999-to-0 rollover.
- R9: The milliseconds count never leaves the range 0 to 999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 kHz enable, one cycle wide per millisecond |
| rdEn | input | 1 | Read request for the offset on `rdAddr` |
| rdAddr | input | ADDR_W (8) | Register byte offset |
| rdData | output | DATA_W (32) | Registered read data, valid one cycle after the request |

## Verification
The hardest situations to reach are the seconds wrap and a milliseconds read that falls on the very edge where 999 rolls to 0.

For the wrap, the bench uses a second instance with a 4-bit seconds count. It ticks that instance on every clock for 15,999 cycles, which brings it to second 15 and millisecond 999, and then gives one more tick.

For the rollover read, the bench walks the full-width instance to millisecond 999. It then issues the milliseconds read in the same cycle as the wrapping tick and checks that the returned pair is (0 s, 999 ms), not a torn (1 s, 999 ms).

To check that the shadow holds, the bench lets a whole second elapse with only live-seconds and shadow reads. The shadow must keep its old value while the live seconds count advances.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int OFF_LIVE_SEC   = 'h08;
  localparam int OFF_SHADOW_SEC = 'h0C;
  localparam int OFF_MILLIS     = 'h10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_SEC    = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_MS     = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    msInc;
    logic    msClr;
    logic    secInc;
    logic    shadowLd;
    rd_sel_e rdSel;
  } rtc_strobe_t;

endpackage

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              tick,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              msAtLast,
  output rtc_strobe_t       strobe
);

  logic hitSec;
  logic hitShadow;
  logic hitMs;

  assign hitSec    = rdEn && (rdAddr == ADDR_W'(OFF_LIVE_SEC));
  assign hitShadow = rdEn && (rdAddr == ADDR_W'(OFF_SHADOW_SEC));
  assign hitMs     = rdEn && (rdAddr == ADDR_W'(OFF_MILLIS));

  always_comb begin
    strobe          = '0;
    strobe.msInc    = tick && !msAtLast;
    strobe.msClr    = tick && msAtLast;
    strobe.secInc   = tick && msAtLast;
    strobe.shadowLd = hitMs;
    if (hitSec)         strobe.rdSel = SEL_SEC;
    else if (hitShadow) strobe.rdSel = SEL_SHADOW;
    else if (hitMs)     strobe.rdSel = SEL_MS;
    else                strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/rtc_shadow_dp.sv
module rtc_shadow_dp
  import rtc_shadow_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  rtc_strobe_t       strobe,
  output logic              msAtLast,
  output logic [MS_W-1:0]   msVal,
  output logic [SEC_W-1:0]  secVal,
  output logic [SEC_W-1:0]  shadowVal,
  output logic [DATA_W-1:0] rdData
);

  logic [MS_W-1:0]   msQ;
  logic [SEC_W-1:0]  secQ;
  logic [SEC_W-1:0]  shadowQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] rdNext;

  assign msAtLast = (msQ == MS_W'(MS_PER_SEC - 1));

  always_comb begin
    unique case (strobe.rdSel)
      SEL_SEC:    rdNext = DATA_W'(secQ);
      SEL_SHADOW: rdNext = DATA_W'(shadowQ);
      SEL_MS:     rdNext = DATA_W'(msQ);
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msQ     <= '0;
      secQ    <= '0;
      shadowQ <= '0;
      rdQ     <= '0;
    end else begin
      if (strobe.msClr)         msQ <= '0;
      else if (strobe.msInc)    msQ <= msQ + 1'b1;
      if (strobe.secInc)        secQ <= secQ + 1'b1;
      if (strobe.shadowLd)      shadowQ <= secQ;
      rdQ <= rdNext;
    end
  end

  assign msVal     = msQ;
  assign secVal    = secQ;
  assign shadowVal = shadowQ;
  assign rdData    = rdQ;

endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
  import rtc_shadow_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  rtc_strobe_t      strobe;
  logic             msAtLast;
  logic [MS_W-1:0]  msVal;
  logic [SEC_W-1:0] secVal;
  logic [SEC_W-1:0] shadowVal;

  rtc_shadow_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .tick     (tick),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .msAtLast (msAtLast),
    .strobe   (strobe)
  );

  rtc_shadow_dp #(
    .SEC_W      (SEC_W),
    .MS_PER_SEC (MS_PER_SEC),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .msAtLast  (msAtLast),
    .msVal     (msVal),
    .secVal    (secVal),
    .shadowVal (shadowVal),
    .rdData    (rdData)
  );

endmodule

// File: rtl/rtc_shadow_timer_chk.sv
module rtc_shadow_timer_chk #(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [MS_W-1:0]   msVal,
  input logic [SEC_W-1:0]  secVal,
  input logic [SEC_W-1:0]  shadowVal
);

  logic msRead;
  logic mapped;
  assign msRead = rdEn && (rdAddr == ADDR_W'('h10));
  assign mapped = (rdAddr == ADDR_W'('h08)) || (rdAddr == ADDR_W'('h0C)) ||
                  (rdAddr == ADDR_W'('h10));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (msVal == '0 && secVal == '0 && shadowVal == '0 && rdData == '0));

  // R2
  ms_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && msVal != MS_W'(MS_PER_SEC - 1)) |=>
      (msVal == MS_W'($past(msVal) + 1'b1) && $stable(secVal)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(msVal) && $stable(secVal)));

  // R3
  ms_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && msVal == MS_W'(MS_PER_SEC - 1)) |=>
      (msVal == '0 && secVal == SEC_W'($past(secVal) + 1'b1)));

  // R5
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    msRead |=> (shadowVal == $past(secVal)));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !msRead |=> $stable(shadowVal));

  // R6
  ms_read_data_chk: assert property (@(posedge clk) disable iff (rst)
    msRead |=> (rdData == DATA_W'($past(msVal))));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdEn || !mapped) |=> (rdData == '0));

  // R9
  ms_range_chk: assert property (@(posedge clk) disable iff (rst)
    msVal <= MS_W'(MS_PER_SEC - 1));

endmodule

bind rtc_shadow_timer rtc_shadow_timer_chk #(
  .SEC_W      (SEC_W),
  .MS_PER_SEC (MS_PER_SEC),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .msVal     (msVal),
  .secVal    (secVal),
  .shadowVal (shadowVal)
);

// File: tb/test_rtc_shadow_timer.sv
module test_rtc_shadow_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;

  logic        nTick = 1'b0;
  logic        nRdEn = 1'b0;
  logic [7:0]  nAddr = '0;
  logic [31:0] nData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_SEC = 8'h08;
  localparam logic [7:0] A_SHD = 8'h0C;
  localparam logic [7:0] A_MS  = 8'h10;

  always #2 clk = ~clk;

  rtc_shadow_timer i_rtc_shadow_timer (
    .clk(clk), .rst(rst), .tick(tick), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  rtc_shadow_timer #(.SEC_W(4)) i_rtc_shadow_timer_narrow (
    .clk(clk), .rst(rst), .tick(nTick), .rdEn(nRdEn), .rdAddr(nAddr), .rdData(nData)
  );

  // {tick, rdEn, addr[7:0], expected rdData[31:0]} starting from ms=0, s=0
  localparam int NVEC = 8;
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 1'b1, A_MS,  32'd0},
    {1'b1, 1'b1, A_MS,  32'd1},
    {1'b0, 1'b1, A_MS,  32'd2},
    {1'b0, 1'b1, A_SEC, 32'd0},
    {1'b0, 1'b1, A_SHD, 32'd0},
    {1'b1, 1'b1, 8'h04, 32'd0},
    {1'b0, 1'b0, A_MS,  32'd0},
    {1'b0, 1'b1, A_MS,  32'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic e, input logic [7:0] a);
    tick = t; rdEn = e; rdAddr = a;
    @(negedge clk);
    tick = 1'b0; rdEn = 1'b0;
  endtask

  task automatic ncyc(input logic t, input logic e, input logic [7:0] a);
    nTick = t; nRdEn = e; nAddr = a;
    @(negedge clk);
    nTick = 1'b0; nRdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state on all mapped offsets
    cyc(0, 1, A_MS);  chk("R1 ms after reset", rdData, 0);
    cyc(0, 1, A_SEC); chk("R1 sec after reset", rdData, 0);
    cyc(0, 1, A_SHD); chk("R1 shadow after reset", rdData, 0);

    // R2 R6 R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][41], VEC[i][40], VEC[i][39:32]);
      chk($sformatf("R2/R6/R7 vector %0d", i), rdData, VEC[i][31:0]);
    end

    // R2: advance from 3 to 999
    for (int i = 0; i < 996; i++) cyc(1, 0, 8'h00);
    cyc(0, 1, A_MS);  chk("R2 ms at 999", rdData, 999);
    cyc(0, 1, A_SEC); chk("R2 sec before wrap", rdData, 0);

    // R8 R3: ms read on the wrapping edge
    cyc(1, 1, A_MS);  chk("R8 ms read on rollover", rdData, 999);
    cyc(0, 1, A_SHD); chk("R8 shadow pairs with old second", rdData, 0);
    cyc(0, 1, A_MS);  chk("R3 ms wrapped to 0", rdData, 0);
    cyc(0, 1, A_SEC); chk("R3 sec incremented", rdData, 1);

    // R5: shadow load then hold across a full second
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'h00);
    cyc(0, 1, A_MS);  chk("R5 ms before load", rdData, 5);
    cyc(0, 1, A_SHD); chk("R5 shadow loaded", rdData, 1);
    for (int i = 0; i < 1000; i++) begin
      if (i % 2 == 0) cyc(1, 1, A_SEC);
      else            cyc(1, 1, A_SHD);
    end
    cyc(0, 1, A_SEC); chk("R5 live sec advanced", rdData, 2);
    cyc(0, 1, A_SHD); chk("R5 shadow held", rdData, 1);

    // R7: unmapped offsets
    cyc(0, 1, 8'h00); chk("R7 offset 0x00", rdData, 0);
    cyc(0, 1, 8'h09); chk("R7 offset 0x09", rdData, 0);
    cyc(0, 1, 8'h14); chk("R7 offset 0x14", rdData, 0);
    cyc(0, 1, 8'hFF); chk("R7 offset 0xFF", rdData, 0);

    // R4: narrow seconds counter wraps
    for (int i = 0; i < 15999; i++) ncyc(1, 0, 8'h00);
    ncyc(0, 1, A_SEC); chk("R4 narrow sec at 15", nData, 15);
    ncyc(0, 1, A_MS);  chk("R4 narrow ms at 999", nData, 999);
    ncyc(1, 0, 8'h00);
    ncyc(0, 1, A_SEC); chk("R4 narrow sec wrapped", nData, 0);
    ncyc(0, 1, A_MS);  chk("R4 narrow ms wrapped", nData, 0);

    // R1: reset in mid-run
    cyc(0, 1, A_MS);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rdData cleared by reset", rdData, 0);
    cyc(0, 1, A_MS);  chk("R1 ms after mid reset", rdData, 0);
    cyc(0, 1, A_SEC); chk("R1 sec after mid reset", rdData, 0);
    cyc(0, 1, A_SHD); chk("R1 shadow after mid reset", rdData, 0);

    finishRun();
  end

endmodule